// File: doc/BRIEF.md
# Lock-in Frequency-Locked Loop

This block follows the fundamental frequency of one line-voltage channel. It produces a frequency word and a running reference phase, and every harmonic extractor on the chip shares that phase. Each accepted sample is multiplied by the loop's own sine and cosine references. The two products pass through a two-pole low-pass filter, and a vectoring CORDIC turns the filtered pair into a phase error. The difference between successive phase errors, wrapped to a signed half turn, is the frequency error in frequency-word units. A proportional-integral controller with a clamped integrator turns that error into a correction Δf. The correction is added to the nominal 60 Hz word, and the sum steps a phase accumulator once per sample.

Phase and frequency are both held as fractions of a turn over 2^PH_W. With the default 40.02 kHz sample rate and PH_W = 24, one frequency-word LSB is about 2.39 mHz, and the nominal word is 25153. A lock flag is evaluated at the end of every window of `lock_len` samples. A start flag tells the extractors when the initial tracking interval has passed.

Top module: `lockin_fll`

## Requirements
- R1: After reset, `ref_phase` is 0, `freq_word` equals NOM_WORD (25153), and `locked` and `extract_go` are 0.
- R2: Each sample with `smp_valid` high advances `ref_phase` by the `freq_word` value held before that sample, modulo 2^PH_W, where 2^PH_W is one full turn.
- R3: While `smp_valid` is low, `smp` is ignored and none of `freq_word`, `ref_phase`, `locked` or `extract_go` changes.
- R4: After a step of up to ±1.5 Hz from nominal, `freq_word` is within 80 LSB (about 0.19 Hz) of the input frequency word f·2^PH_W/fs by the time `extract_go` rises, 8004 samples (200 ms) after reset.
- R5: In steady state, the mean of `freq_word` over 2048 samples is within 20 LSB of the input frequency word, including when a 10 % third harmonic is present.
- R6: The correction Δf = `freq_word` − NOM_WORD never leaves ±CLAMP_WORD (838 LSB, about 2 Hz). A sustained input 5 Hz above or below nominal pins `freq_word` to exactly NOM_WORD+838 or NOM_WORD−838.
- R7: `extract_go` rises exactly at the START_SAMPLES-th accepted sample (8004 by default) and then stays high until reset.
- R8: At the end of each window of `lock_len` accepted samples, `locked` is set when |Δf − Δf at the previous window end| < `lock_thr` and Δf is not at a clamp limit. Otherwise it is cleared. With a constant Δf, `locked` rises at the `lock_len`-th sample.
- R9: The frequency error is the wrapped difference of successive phase errors. The first sample after reset only primes it, so a silent input keeps `freq_word` at NOM_WORD, and a phase error that wraps through a half turn causes no spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Qualifies `smp` for this cycle |
| smp | input | SMP_W | Signed voltage sample |
| lock_len | input | LEN_W | Lock evaluation window, in samples |
| lock_thr | input | LEN_W | Largest Δf drift per window still counted as locked, in LSB |
| freq_word | output | PH_W | Tracked frequency, in turns per sample × 2^PH_W |
| ref_phase | output | PH_W | Reference phase, in turns × 2^PH_W |
| locked | output | 1 | Lock status |
| extract_go | output | 1 | Tracking interval elapsed; extraction may start |

## Verification
The bench applies frequency steps of +1.5 Hz and −1.5 Hz. A loop with the wrong feedback sign or the wrong phase-error sign would run away to a clamp limit instead of settling. Offsets of ±5 Hz force the phase error to wrap through a half turn many times while the correction is pinned. A difference that is not wrapped would throw the correction between its limits, and a missing clamp would let the word drift past ±838 LSB. A silent input checks that the first sample does not create a false frequency kick. The same input pins down the exact sample on which `locked` and `extract_go` rise, so an off-by-one in the window or start counter shows up. The ±5 Hz tests also confirm that a loop pinned at its limit never reports lock.

// File: rtl/lockin_fll.sv
module lockin_fll #(
  parameter int SMP_W         = 16,
  parameter int PH_W          = 24,
  parameter int LEN_W         = 16,
  parameter int NOM_WORD      = 25153,
  parameter int CLAMP_WORD    = 838,
  parameter int FILT_SH       = 9,
  parameter int KP_SH         = 6,
  parameter int KI_SH         = 11,
  parameter int CORDIC_N      = 16,
  parameter int START_SAMPLES = 8004
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [LEN_W-1:0]        lock_len,
  input  logic [LEN_W-1:0]        lock_thr,
  output logic [PH_W-1:0]         freq_word,
  output logic [PH_W-1:0]         ref_phase,
  output logic                    locked,
  output logic                    extract_go
);
  localparam int REF_W = 16;
  localparam int PR_W  = SMP_W + REF_W;
  localparam int FW    = PR_W + FILT_SH + 2;
  localparam int CW    = PR_W + 3;
  localparam int AW    = PH_W + KI_SH + 2;
  localparam int SW    = PH_W + 2;
  localparam int SC_W  = $clog2(START_SAMPLES + 1);
  localparam logic [PH_W-1:0]        QTR     = PH_W'(1) << (PH_W - 2);
  localparam logic [PH_W-1:0]        HALF    = PH_W'(1) << (PH_W - 1);
  localparam logic signed [AW-1:0]   ACC_LIM = AW'(CLAMP_WORD) <<< KI_SH;
  localparam logic signed [SW-1:0]   DF_LIM  = SW'(CLAMP_WORD);
  localparam logic signed [PH_W-1:0] DF_MAX  = PH_W'(CLAMP_WORD);

  function automatic logic signed [REF_W-1:0] psin(input logic [PH_W-1:0] p);
    logic [15:0] h;
    logic [31:0] m;
    logic [16:0] mag;
    h   = p[PH_W-2 -: 16];
    m   = 32'(h) * (32'd65536 - 32'(h));
    mag = 17'(m >> 15);
    if (mag > 17'd32767) mag = 17'd32767;
    psin = p[PH_W-1] ? -$signed(mag[15:0]) : $signed(mag[15:0]);
  endfunction

  function automatic logic [PH_W-1:0] atan_turn(input int i);
    logic [31:0] t;
    case (i)
      0:  t = 32'd536870912;
      1:  t = 32'd316933376;
      2:  t = 32'd167458816;
      3:  t = 32'd85004800;
      4:  t = 32'd42667264;
      5:  t = 32'd21354496;
      6:  t = 32'd10679808;
      7:  t = 32'd5340160;
      8:  t = 32'd2670080;
      9:  t = 32'd1335040;
      10: t = 32'd667648;
      11: t = 32'd333824;
      12: t = 32'd166912;
      13: t = 32'd83456;
      14: t = 32'd41728;
      15: t = 32'd20736;
      default: t = 32'd683565276 >> i;
    endcase
    atan_turn = PH_W'(t >> (32 - PH_W));
  endfunction

  function automatic logic signed [FW-1:0] lp(input logic signed [FW-1:0] s,
                                               input logic signed [FW-1:0] x);
    lp = s + ((x - s) >>> FILT_SH);
  endfunction

  logic signed [REF_W-1:0] sin_r, cos_r;
  logic signed [PR_W-1:0]  mix_i, mix_q;
  logic signed [FW-1:0]    wx_i, wx_q, i1, i2, q1, q2;

  assign sin_r = psin(ref_phase);
  assign cos_r = psin(ref_phase + QTR);
  assign mix_i = smp * sin_r;
  assign mix_q = smp * cos_r;
  assign wx_i  = FW'(mix_i) <<< FILT_SH;
  assign wx_q  = FW'(mix_q) <<< FILT_SH;

  logic signed [CW-1:0] cx, cy, tx;
  logic [PH_W-1:0]      ang;

  always_comb begin
    cx  = CW'(i2 >>> FILT_SH);
    cy  = CW'(q2 >>> FILT_SH);
    tx  = '0;
    ang = '0;
    if (cx < 0) begin
      cx  = -cx;
      cy  = -cy;
      ang = HALF;
    end
    for (int n = 0; n < CORDIC_N; n++) begin
      if (cy >= 0) begin
        tx  = cx + (cy >>> n);
        cy  = cy - (cx >>> n);
        ang = ang + atan_turn(n);
      end else begin
        tx  = cx - (cy >>> n);
        cy  = cy + (cx >>> n);
        ang = ang - atan_turn(n);
      end
      cx = tx;
    end
  end

  logic [PH_W-1:0]        ang_prev;
  logic                   primed;
  logic signed [PH_W-1:0] ferr, df, df_n, mark;
  logic signed [AW-1:0]   acc, acc_sum, acc_n;
  logic signed [SW-1:0]   pi_sum;
  logic                   sat_n;

  assign ferr = $signed(ang - ang_prev);

  always_comb begin
    acc_sum = acc + AW'(ferr);
    if (acc_sum > ACC_LIM)       acc_n = ACC_LIM;
    else if (acc_sum < -ACC_LIM) acc_n = -ACC_LIM;
    else                         acc_n = acc_sum;
    pi_sum = SW'(acc_n >>> KI_SH) + SW'(ferr >>> KP_SH);
    if (!primed)                df_n = df;
    else if (pi_sum > DF_LIM)   df_n = DF_MAX;
    else if (pi_sum < -DF_LIM)  df_n = -DF_MAX;
    else                        df_n = PH_W'(pi_sum);
  end

  assign sat_n     = (df_n == DF_MAX) || (df_n == -DF_MAX);
  assign freq_word = PH_W'(NOM_WORD) + $unsigned(df);

  logic [LEN_W-1:0]     win_cnt;
  logic                 win_end;
  logic signed [PH_W:0] drift, drift_abs;
  logic [SC_W-1:0]      go_cnt;

  assign win_end   = ({1'b0, win_cnt} + (LEN_W+1)'(1)) >= {1'b0, lock_len};
  assign drift     = (PH_W+1)'(df_n) - (PH_W+1)'(mark);
  assign drift_abs = drift[PH_W] ? -drift : drift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i1 <= '0; i2 <= '0; q1 <= '0; q2 <= '0;
      ang_prev   <= '0;
      primed     <= 1'b0;
      acc        <= '0;
      df         <= '0;
      ref_phase  <= '0;
      win_cnt    <= '0;
      mark       <= '0;
      locked     <= 1'b0;
      go_cnt     <= '0;
      extract_go <= 1'b0;
    end else if (smp_valid) begin
      i1 <= lp(i1, wx_i);
      i2 <= lp(i2, i1);
      q1 <= lp(q1, wx_q);
      q2 <= lp(q2, q1);
      ang_prev  <= ang;
      primed    <= 1'b1;
      if (primed) acc <= acc_n;
      df        <= df_n;
      ref_phase <= ref_phase + freq_word;
      if (win_end) begin
        win_cnt <= '0;
        mark    <= df_n;
        locked  <= (drift_abs < $signed({{(PH_W+1-LEN_W){1'b0}}, lock_thr})) && !sat_n;
      end else begin
        win_cnt <= win_cnt + LEN_W'(1);
      end
      if (!extract_go) begin
        go_cnt <= go_cnt + SC_W'(1);
        if (go_cnt == SC_W'(START_SAMPLES - 1)) extract_go <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockin_fll_chk.sv
module lockin_fll_chk #(
  parameter int PH_W       = 24,
  parameter int NOM_WORD   = 25153,
  parameter int CLAMP_WORD = 838
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_valid,
  input logic [PH_W-1:0] freq_word,
  input logic [PH_W-1:0] ref_phase,
  input logic            locked,
  input logic            extract_go
);
  localparam logic signed [PH_W-1:0] LIM = PH_W'(CLAMP_WORD);
  logic signed [PH_W-1:0] corr;
  assign corr = $signed(freq_word - PH_W'(NOM_WORD));

  p_corr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (corr <= LIM) && (corr >= -LIM));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> ref_phase == PH_W'($past(ref_phase) + $past(freq_word)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(ref_phase) && $stable(freq_word) && $stable(locked) && $stable(extract_go));

  p_go_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    extract_go |=> extract_go);

  p_lock_on_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !$rose(locked));
endmodule

bind lockin_fll lockin_fll_chk #(
  .PH_W(PH_W), .NOM_WORD(NOM_WORD), .CLAMP_WORD(CLAMP_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .freq_word(freq_word),
  .ref_phase(ref_phase), .locked(locked), .extract_go(extract_go)
);

// File: tb/lockin_fll_tb_top.sv
module lockin_fll_tb_top;
  localparam int  PH_W   = 24;
  localparam int  NOM    = 25153;
  localparam int  CLAMP  = 838;
  localparam int  START  = 8004;
  localparam real FS     = 40020.0;
  localparam real TWO_PI = 6.283185307179586;
  localparam real AMP    = 20000.0;
  localparam int  WDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp = '0;
  logic [15:0] lock_len = 16'd1024;
  logic [15:0] lock_thr = 16'd100;
  logic [PH_W-1:0] freq_word, ref_phase;
  logic locked, extract_go;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  int  k = 0;
  real fw_sum = 0.0;
  int  fw_n = 0;

  always #5 clk = ~clk;

  lockin_fll dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp),
    .lock_len(lock_len), .lock_thr(lock_thr), .freq_word(freq_word),
    .ref_phase(ref_phase), .locked(locked), .extract_go(extract_go)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic real word_of(input real f);
    return f / FS * 16777216.0;
  endfunction

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = 0;
  endtask

  task automatic feed(input real f, input real h3, input int n, input bit avg);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (avg && j > 0) begin
        fw_sum += real'(freq_word);
        fw_n++;
      end
      smp = 16'($rtoi(AMP * ($sin(TWO_PI * f * k / FS) + h3 * $sin(3.0 * TWO_PI * f * k / FS))));
      smp_valid = 1'b1;
      k++;
    end
    @(negedge clk);
    if (avg) begin
      fw_sum += real'(freq_word);
      fw_n++;
    end
    smp_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk("R1 ref_phase", ref_phase == 0, ref_phase, 0);
    chk("R1 freq_word", freq_word == NOM, freq_word, NOM);
    chk("R1 flags", {locked, extract_go} == 2'b00, {locked, extract_go}, 0);
  endtask

  task automatic t_phase_accum();
    longint exp_ph;
    do_reset();
    feed(0.0, 0.0, 100, 1'b0);
    exp_ph = (100 * longint'(NOM)) % (64'd1 << PH_W);
    chk("R2 phase after 100 samples", ref_phase == exp_ph[PH_W-1:0], ref_phase, exp_ph);
    chk("R9 silent input keeps nominal", freq_word == NOM, freq_word, NOM);
  endtask

  task automatic t_idle_hold();
    logic [PH_W-1:0] ph0, fw0;
    logic lk0;
    do_reset();
    feed(60.0, 0.0, 300, 1'b0);
    ph0 = ref_phase;
    fw0 = freq_word;
    lk0 = locked;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      smp = 16'($urandom);
    end
    @(negedge clk);
    chk("R3 phase held", ref_phase == ph0, ref_phase, ph0);
    chk("R3 freq held", freq_word == fw0, freq_word, fw0);
    chk("R3 lock held", locked == lk0, locked, lk0);
  endtask

  task automatic t_lock_window();
    lock_len = 16'd64;
    lock_thr = 16'd10;
    do_reset();
    feed(0.0, 0.0, 63, 1'b0);
    chk("R8 no lock before window end", locked == 1'b0, locked, 0);
    feed(0.0, 0.0, 1, 1'b0);
    chk("R8 lock at window end", locked == 1'b1, locked, 1);
  endtask

  task automatic t_start_flag();
    lock_len = 16'd1024;
    lock_thr = 16'd100;
    do_reset();
    feed(0.0, 0.0, START - 1, 1'b0);
    chk("R7 go low before interval", extract_go == 1'b0, extract_go, 0);
    feed(0.0, 0.0, 1, 1'b0);
    chk("R7 go at interval", extract_go == 1'b1, extract_go, 1);
    feed(0.0, 0.0, 50, 1'b0);
    chk("R7 go sticky", extract_go == 1'b1, extract_go, 1);
  endtask

  task automatic t_track(input real f, input real h3);
    longint tgt, err;
    real avg;
    lock_len = 16'd1024;
    lock_thr = 16'd100;
    tgt = longint'($rtoi(word_of(f) + 0.5));
    do_reset();
    feed(f, h3, START, 1'b0);
    chk("R7 go after tracking interval", extract_go == 1'b1, extract_go, 1);
    err = longint'(freq_word) - tgt;
    chk("R4 settled by interval end", err <= 80 && err >= -80, freq_word, tgt);
    feed(f, h3, 16000, 1'b0);
    chk("R8 locked in steady state", locked == 1'b1, locked, 1);
    fw_sum = 0.0;
    fw_n = 0;
    feed(f, h3, 2048, 1'b1);
    avg = fw_sum / fw_n;
    err = longint'($rtoi(avg + 0.5)) - tgt;
    chk("R5 mean word", err <= 20 && err >= -20, longint'($rtoi(avg + 0.5)), tgt);
  endtask

  task automatic t_clamp(input real f, input int sgn);
    longint exp_fw;
    lock_len = 16'd1024;
    lock_thr = 16'd100;
    exp_fw = longint'(NOM + sgn * CLAMP);
    do_reset();
    feed(f, 0.0, 12000, 1'b0);
    chk("R6 pinned at clamp", freq_word == exp_fw[PH_W-1:0], freq_word, exp_fw);
    feed(f, 0.0, 1024, 1'b0);
    chk("R6 still pinned", freq_word == exp_fw[PH_W-1:0], freq_word, exp_fw);
    chk("R8 no lock while clamped", locked == 1'b0, locked, 0);
  endtask

  initial begin
    t_reset_state();
    t_phase_accum();
    t_idle_hold();
    t_lock_window();
    t_start_flag();
    t_track(61.5, 0.1);
    t_track(58.5, 0.0);
    t_clamp(65.0, 1);
    t_clamp(55.0, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule